// File: doc/BRIEF.md
# Leader Cell Detector

This block walks a small gray-scale image held in an external memory and decides, pixel by pixel, whether each one is a leader cell. For every pixel it fetches the pixel itself and then each of its eight surrounding pixels that lie inside the image. For each surrounding pixel it forms a similarity weight and adds it to a running sum. When the pixel's sum is strictly larger than a programmable threshold, a 1 is written to a one-bit-per-pixel output map; otherwise a 0 is written. Leadership therefore depends on how strongly a pixel couples to its surroundings, not on its own brightness.

A controller loads the threshold on `thr_in` and pulses `start`. The block latches the threshold and scans the image in raster order through a read port with one cycle of latency. It writes one map bit per pixel and pulses `done` once the last bit is out. The default image is 5 by 5 pixels of 8 bits each.

The controller has five states. IDLE waits for start and moves to ISSUE. ISSUE requests the current neighbour. It goes to ACCUM if that neighbour exists, skips to the next index if it does not, and goes to WRITE after the last index. ACCUM takes in the returned pixel and then returns to ISSUE, or goes to WRITE after the last index. WRITE stores the map bit and returns to ISSUE for the next pixel, or goes to FINISH after the last pixel. FINISH raises done and returns to IDLE.

Top module: `leader_cell_detector`

## Requirements
- R1: A start seen while idle begins one scan. The scan writes exactly one map bit per pixel, with map addresses increasing from 0 to 24, where the address of row r and column c is r*5+c.
- R2: The weight between a pixel of value a and a neighbour of value b is floor(255 / (1 + |a - b|)), so equal pixels give 255 and pixels 255 apart give 0.
- R3: A pixel's sum covers its 8-connected neighbours, and only those that lie inside the image: 3 for a corner, 5 for an edge, 8 for an interior pixel.
- R4: The map bit is 1 exactly when the sum is strictly greater than the threshold. A sum equal to the threshold gives 0.
- R5: The threshold is a 12-bit unsigned value. Settings such as 200 and 1000 behave per R4, and 4095 yields an all-zero map.
- R6: Sums up to 8*255 = 2040 are held exactly, so a uniform image with threshold 2039 marks every interior pixel and no other pixel.
- R7: done is high for exactly one cycle, the cycle after the write of pixel 24, and at no other time.
- R8: A start that arrives while a scan is running, including the done cycle, is ignored. No scan restarts and no extra scan follows.
- R9: The threshold is captured when start is accepted. Changes to thr_in during a scan do not affect that scan's map.
- R10: During and right after reset, rd_en, wr_en and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one scan; acted on only while idle |
| thr_in | input | 12 | Leader threshold, captured at an accepted start |
| rd_en | output | 1 | Pixel read request |
| rd_addr | output | 5 | Pixel read address, raster order |
| rd_data | input | 8 | Pixel value, valid the cycle after rd_en |
| wr_en | output | 1 | Map write strobe |
| wr_addr | output | 5 | Map write address |
| wr_data | output | 1 | Leader bit for wr_addr |
| done | output | 1 | One-cycle pulse after the last map write |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. The bench raises start during the very cycle in which done is high. It then watches the ports for many cycles and fails the run if any read or write appears, or if done pulses again. A second overlap exercised is a start together with a threshold change in the middle of a scan. The scoreboard, loaded with bits computed from the originally latched threshold, flags any restart at address 0 or any bit that follows the new threshold.

// File: rtl/leader_pkg.sv
package leader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_ACCUM,
        ST_WRITE,
        ST_FINISH
    } scan_state_t;

    localparam int NB_CNT = 8;
    localparam int IDX_W  = 4;

endpackage

// File: rtl/leader_nbr_addr.sv
module leader_nbr_addr #(
    parameter int IMG_W  = 5,
    parameter int IMG_H  = 5,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int ADDR_W = 5,
    parameter int IDX_W  = 4
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [IDX_W-1:0]  idx,
    output logic              valid,
    output logic [ADDR_W-1:0] addr
);

    // idx 0 selects the pixel itself; idx 1..8 walk the 3x3 window
    // skipping its centre slot.
    always_comb begin
        int slot;
        int r;
        int c;
        if (idx == '0) begin
            slot = 4;
        end else if (int'(idx) - 1 < 4) begin
            slot = int'(idx) - 1;
        end else begin
            slot = int'(idx);
        end
        r     = int'(row) + slot / 3 - 1;
        c     = int'(col) + slot % 3 - 1;
        valid = (r >= 0) && (r < IMG_H) && (c >= 0) && (c < IMG_W);
        addr  = valid ? ADDR_W'(r * IMG_W + c) : '0;
    end

endmodule

// File: rtl/leader_weight.sv
module leader_weight #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] weight
);

    localparam int MAXV = (1 << PIX_W) - 1;

    logic [PIX_W-1:0] diff;
    logic [PIX_W:0]   denom;
    logic [PIX_W:0]   numer;

    always_comb begin
        diff   = (pix_a > pix_b) ? (pix_a - pix_b) : (pix_b - pix_a);
        denom  = {1'b0, diff} + (PIX_W+1)'(1);
        numer  = (PIX_W+1)'(MAXV);
        weight = PIX_W'(numer / denom);
    end

endmodule

// File: rtl/leader_accum.sv
module leader_accum #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 11,
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [PIX_W-1:0] add_val,
    input  logic [THR_W-1:0] thr,
    output logic [ACC_W-1:0] sum,
    output logic             is_leader
);

    localparam int CMP_W = (ACC_W > THR_W) ? ACC_W : THR_W;

    logic [CMP_W-1:0] sum_ext;
    logic [CMP_W-1:0] thr_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + ACC_W'(add_val);
        end
    end

    always_comb begin
        sum_ext   = CMP_W'(sum);
        thr_ext   = CMP_W'(thr);
        is_leader = sum_ext > thr_ext;
    end

endmodule

// File: rtl/leader_cell_detector.sv
module leader_cell_detector
    import leader_pkg::*;
#(
    parameter int IMG_W = 5,
    parameter int IMG_H = 5,
    parameter int PIX_W = 8,
    parameter int THR_W = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [THR_W-1:0]                     thr_in,
    output logic                                 rd_en,
    output logic [$clog2(IMG_W*IMG_H)-1:0]       rd_addr,
    input  logic [PIX_W-1:0]                     rd_data,
    output logic                                 wr_en,
    output logic [$clog2(IMG_W*IMG_H)-1:0]       wr_addr,
    output logic                                 wr_data,
    output logic                                 done
);

    localparam int NPIX   = IMG_W * IMG_H;
    localparam int ADDR_W = $clog2(NPIX);
    localparam int ROW_W  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int ACC_W  = $clog2(NB_CNT * ((1 << PIX_W) - 1) + 1);

    scan_state_t       state;
    scan_state_t       state_nx;
    logic              busy;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [ADDR_W-1:0] pix_addr;
    logic [IDX_W-1:0]  nb_idx;
    logic [PIX_W-1:0]  center;
    logic [THR_W-1:0]  thr_q;
    logic              nb_valid;
    logic [ADDR_W-1:0] nb_addr;
    logic [PIX_W-1:0]  weight;
    logic              acc_clr;
    logic              acc_add;
    logic [ACC_W-1:0]  acc_sum;
    logic              is_leader;
    logic              last_pix;
    logic              last_nb;
    logic              last_col;

    assign busy     = (state != ST_IDLE);
    assign last_pix = (pix_addr == ADDR_W'(NPIX - 1));
    assign last_nb  = (nb_idx == IDX_W'(NB_CNT));
    assign last_col = (col == COL_W'(IMG_W - 1));

    leader_nbr_addr #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_nbr (
        .row  (row),
        .col  (col),
        .idx  (nb_idx),
        .valid(nb_valid),
        .addr (nb_addr)
    );

    leader_weight #(
        .PIX_W(PIX_W)
    ) u_weight (
        .pix_a (center),
        .pix_b (rd_data),
        .weight(weight)
    );

    leader_accum #(
        .PIX_W(PIX_W),
        .ACC_W(ACC_W),
        .THR_W(THR_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add_en   (acc_add),
        .add_val  (weight),
        .thr      (thr_q),
        .sum      (acc_sum),
        .is_leader(is_leader)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start && !busy) state_nx = ST_ISSUE;
            ST_ISSUE: begin
                if (nb_valid)     state_nx = ST_ACCUM;
                else if (last_nb) state_nx = ST_WRITE;
                else              state_nx = ST_ISSUE;
            end
            ST_ACCUM:  state_nx = last_nb ? ST_WRITE : ST_ISSUE;
            ST_WRITE:  state_nx = last_pix ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Scan position, centre pixel and latched threshold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row      <= '0;
            col      <= '0;
            pix_addr <= '0;
            nb_idx   <= '0;
            center   <= '0;
            thr_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        thr_q    <= thr_in;
                        row      <= '0;
                        col      <= '0;
                        pix_addr <= '0;
                        nb_idx   <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (!nb_valid && !last_nb) nb_idx <= nb_idx + IDX_W'(1);
                end
                ST_ACCUM: begin
                    if (nb_idx == '0) center <= rd_data;
                    if (!last_nb)     nb_idx <= nb_idx + IDX_W'(1);
                end
                ST_WRITE: begin
                    nb_idx <= '0;
                    if (!last_pix) begin
                        pix_addr <= pix_addr + ADDR_W'(1);
                        if (last_col) begin
                            col <= '0;
                            row <= row + ROW_W'(1);
                        end else begin
                            col <= col + COL_W'(1);
                        end
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        done    = 1'b0;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        rd_addr = nb_addr;
        wr_addr = pix_addr;
        wr_data = is_leader;
        unique case (state)
            ST_IDLE:   acc_clr = start;
            ST_ISSUE:  rd_en   = nb_valid;
            ST_ACCUM:  acc_add = (nb_idx != '0);
            ST_WRITE: begin
                wr_en   = 1'b1;
                acc_clr = 1'b1;
            end
            ST_FINISH: done    = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/leader_cell_detector_chk.sv
module leader_cell_detector_chk #(
    parameter int IMG_W = 5,
    parameter int IMG_H = 5,
    parameter int PIX_W = 8,
    parameter int THR_W = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start,
    input logic                           rd_en,
    input logic [$clog2(IMG_W*IMG_H)-1:0] rd_addr,
    input logic                           wr_en,
    input logic [$clog2(IMG_W*IMG_H)-1:0] wr_addr,
    input logic                           done,
    input logic                           busy,
    input logic [THR_W-1:0]               thr_q,
    input logic [$clog2(8*((1<<PIX_W)-1)+1)-1:0] acc_sum
);

    localparam int NPIX    = IMG_W * IMG_H;
    localparam int ADDR_W  = $clog2(NPIX);
    localparam int MAX_SUM = 8 * ((1 << PIX_W) - 1);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(NPIX - 1)) |=> done); // R7

    AST_RD_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < NPIX)); // R3

    AST_WR_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NPIX)); // R1

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_en, wr_en, done}) <= 1); // R1

    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(thr_q)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_sum) <= MAX_SUM); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en && !done)); // R10

endmodule

bind leader_cell_detector leader_cell_detector_chk #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H),
    .PIX_W(PIX_W),
    .THR_W(THR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .done   (done),
    .busy   (busy),
    .thr_q  (thr_q),
    .acc_sum(acc_sum)
);

// File: tb/leader_cell_detector_test.sv
`timescale 1ns/1ps
module leader_cell_detector_test;

    localparam int W = 5;
    localparam int H = 5;
    localparam int N = W * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] thr_in = '0;
    logic        rd_en;
    logic [4:0]  rd_addr;
    logic [7:0]  rd_data = '0;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic        wr_data;
    logic        done;

    logic [7:0]  img [N];
    int          exp_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    int          wr_count = 0;
    int          rd_count = 0;
    int          done_count = 0;
    bit          exp_done = 1'b0;
    string       cur_tag = "R1";

    always #2 clk = ~clk;

    leader_cell_detector uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .thr_in (thr_in),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .done   (done)
    );

    // Pixel memory, one cycle read latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= img[rd_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_sum(input int p);
        int r = p / W;
        int c = p % W;
        int s = 0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int rr = r + dr;
                int cc = c + dc;
                int d;
                if (dr == 0 && dc == 0) continue;
                if (rr < 0 || rr >= H || cc < 0 || cc >= W) continue;
                d = int'(img[p]) - int'(img[rr * W + cc]);
                if (d < 0) d = -d;
                s += 255 / (1 + d);
            end
        end
        return s;
    endfunction

    // Monitor: scoreboard and done timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) rd_count++;
            if (wr_en) begin
                int got;
                int e;
                wr_count++;
                got = int'(wr_addr) * 2 + int'(wr_data);
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected write"}, got, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(got == e, {cur_tag, " addr*2+bit"}, got, e);
                end
            end
            if (done) done_count++;
            if (done || exp_done) begin
                check(done == exp_done, "R7 done timing", int'(done), int'(exp_done));
            end
            exp_done = wr_en && (wr_addr == 5'(N - 1));
        end
    end

    task automatic push_expected(input int thr);
        for (int p = 0; p < N; p++) begin
            int s = ref_sum(p);
            exp_q.push_back(p * 2 + ((s > thr) ? 1 : 0));
        end
    endtask

    task automatic wait_done(input bit start_on_done);
        do @(negedge clk); while (!done);
        if (start_on_done) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic run_scan(input int thr, input string tag, input bit disturb);
        cur_tag = tag;
        push_expected(thr);
        @(negedge clk);
        thr_in = 12'(thr);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        if (disturb) begin
            repeat (120) @(negedge clk);
            thr_in = 12'd0;
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
        end
        wait_done(1'b0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all bits written"}, exp_q.size(), 0);
    endtask

    task automatic fill_uniform(input int v);
        for (int p = 0; p < N; p++) img[p] = 8'(v);
    endtask

    task automatic fill_gradient();
        for (int p = 0; p < N; p++) img[p] = 8'((p * 13) % 40 + 90);
    endtask

    task automatic fill_checker();
        for (int p = 0; p < N; p++) img[p] = (((p / W) + (p % W)) % 2 == 1) ? 8'd255 : 8'd0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int wc;
        int rc;
        int dc;
        fill_uniform(100);
        repeat (3) @(negedge clk);
        // R10: quiet ports during reset
        check(!rd_en && !wr_en && !done, "R10 reset outputs",
              int'({rd_en, wr_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_en && !wr_en && !done, "R10 after reset",
              int'({rd_en, wr_en, done}), 0);

        // R1 / R3: uniform image, border counts decide the bit
        fill_uniform(100);
        run_scan(1000, "R3", 1'b0);
        // R4: corner sum 765 equals threshold -> 0; one below -> 1
        run_scan(765, "R4", 1'b0);
        run_scan(764, "R4", 1'b0);
        // R6: full interior sum 2040 against 2039
        run_scan(2039, "R6", 1'b0);
        // R2: graded weights
        fill_gradient();
        run_scan(200, "R2", 1'b0);
        run_scan(1000, "R2", 1'b0);
        // R5: high-contrast pattern, typical and maximum thresholds
        fill_checker();
        run_scan(1000, "R5", 1'b0);
        run_scan(4095, "R5", 1'b0);
        // R8/R9: start and threshold change in the middle of a scan
        fill_gradient();
        run_scan(600, "R8/R9", 1'b0);
        run_scan(600, "R9", 1'b1);

        // R8: start raised in the done cycle must not launch a scan
        cur_tag = "R8";
        push_expected(300);
        @(negedge clk);
        thr_in = 12'd300;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        wait_done(1'b1);
        wc = wr_count;
        rc = rd_count;
        dc = done_count;
        repeat (60) @(negedge clk);
        check(wr_count == wc, "R8 no writes after done-cycle start", wr_count, wc);
        check(rd_count == rc, "R8 no reads after done-cycle start", rd_count, rc);
        check(done_count == dc, "R8 no extra done", done_count, dc);
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule